// File: doc/BRIEF.md
# Critical-Word-First Line Fill Unit

This unit sits between the data array of a cache and a 64-bit memory read channel. On a miss it takes the missed address and a request tag, sends one burst command to memory and collects the eight 64-bit beats that make up a 64-byte line. Memory returns the beats in wrap order. The burst starts at the word that missed and the word index rises modulo eight.

The first beat is the word the core is waiting for. It goes to the core in the same cycle it arrives, together with the request tag, so the core does not wait for the rest of the line. Each beat is placed in its correct slot of a line buffer. One cycle after the last beat, a single-cycle completion pulse presents the whole line and its base address to the array. Memory may stall between beats. A new miss is not taken until the completion pulse has been given.

Top module: `cwf_line_fill`

## Requirements
- R1: During and right after reset, req_ready is 1 and mem_cmd_valid, beat_ready, fwd_valid and line_done are all 0.
- R2: A request is taken in a cycle with req_valid and req_ready both high. From the next cycle, mem_cmd_valid is high with mem_cmd_addr equal to the request address with bits 2:0 cleared. Both hold unchanged until a cycle in which mem_cmd_ready is high.
- R3: beat_ready is high from the cycle after the command is taken until eight beats have transferred. A beat transfers only in a cycle with beat_valid and beat_ready both high.
- R4: The start index is bits 5:3 of the request address. Transfer n (counting from 0) is stored as word (start + n) mod 8, and word w occupies bits 64w+63 down to 64w of line_data.
- R5: fwd_valid is high in the cycle of the first beat transfer of a fill and in no other cycle. In that cycle fwd_data equals beat_data and fwd_tag equals the request's tag.
- R6: line_done is a one-cycle pulse in the cycle after the eighth transfer. It carries the completed line_data and a line_addr equal to the request address with bits 5:0 cleared.
- R7: req_ready is low from the cycle after a request is taken through the line_done cycle, and req_valid has no effect in that window. req_ready is high again in the cycle after line_done.
- R8: A cycle in which beat_valid is low during a fill stores nothing, keeps beat_ready high and does not advance the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Unit idle and able to take a miss |
| req_addr | input | ADDR_W | Byte address of the missed word |
| req_tag | input | TAG_W | Tag returned with the forwarded word |
| mem_cmd_valid | output | 1 | Burst command pending |
| mem_cmd_ready | input | 1 | Memory takes the command |
| mem_cmd_addr | output | ADDR_W | Address of the critical word (beat aligned) |
| beat_valid | input | 1 | Memory beat present |
| beat_ready | output | 1 | Unit takes a beat |
| beat_data | input | BEAT_BITS | Beat payload |
| fwd_valid | output | 1 | Critical word forward pulse |
| fwd_data | output | BEAT_BITS | Critical word |
| fwd_tag | output | TAG_W | Tag of the request being filled |
| line_done | output | 1 | Line complete pulse |
| line_addr | output | ADDR_W | Line base address |
| line_data | output | LINE_BYTES*8 | Assembled line, word w at bits 64w+63:64w |

## Verification
The bench runs a fill from every start index at three stall rates on both the command and beat channels. A unit that ignores the start index or wraps wrongly puts words in the wrong slots of line_data. A forward pulse tied to the wrong beat hands the core a neighbouring word, or a stall-blind counter raises it twice. Keeping req_valid high for the whole fill with a changing address shows whether a busy unit takes a second miss or lets its latched tag and address change. Runs with heavy stalls show whether a missing beat is counted, which would raise line_done early with a stale word in the line.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_CMD  = 2'd1,
        FS_BEAT = 2'd2,
        FS_DONE = 2'd3
    } fill_state_e;
endpackage

// File: rtl/cwf_wrap_ctr.sv
module cwf_wrap_ctr #(
    parameter int BEATS = 8,
    localparam int IDX_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [IDX_W-1:0] start_idx,
    output logic [IDX_W-1:0] word_idx,
    output logic             first,
    output logic             last
);
    logic [IDX_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = '0;
        else if (step)
            cnt_d = cnt_q + IDX_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign word_idx = start_idx + cnt_q;
    assign first    = (cnt_q == '0);
    assign last     = (cnt_q == IDX_W'(BEATS - 1));
endmodule

// File: rtl/cwf_line_buf.sv
module cwf_line_buf #(
    parameter int BEATS     = 8,
    parameter int BEAT_BITS = 64,
    localparam int IDX_W    = $clog2(BEATS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [BEAT_BITS-1:0]       wr_data,
    output logic [BEATS*BEAT_BITS-1:0] line
);
    logic [BEAT_BITS-1:0] words_d [BEATS];
    logic [BEAT_BITS-1:0] words_q [BEATS];

    always_comb begin
        for (int w = 0; w < BEATS; w++)
            words_d[w] = words_q[w];
        if (wr_en)
            words_d[wr_idx] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < BEATS; w++)
                words_q[w] <= '0;
        end else begin
            for (int w = 0; w < BEATS; w++)
                words_q[w] <= words_d[w];
        end
    end

    for (genvar g = 0; g < BEATS; g++) begin : g_flat
        assign line[g*BEAT_BITS +: BEAT_BITS] = words_q[g];
    end
endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill
    import cwf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int TAG_W      = 8,
    parameter int LINE_BYTES = 64,
    parameter int BEAT_BITS  = 64,
    localparam int BEATS     = LINE_BYTES * 8 / BEAT_BITS,
    localparam int IDX_W     = $clog2(BEATS),
    localparam int WORD_LO   = $clog2(BEAT_BITS / 8),
    localparam int LINE_LO   = $clog2(LINE_BYTES),
    localparam int LINE_BITS = LINE_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [TAG_W-1:0]     req_tag,
    output logic                 mem_cmd_valid,
    input  logic                 mem_cmd_ready,
    output logic [ADDR_W-1:0]    mem_cmd_addr,
    input  logic                 beat_valid,
    output logic                 beat_ready,
    input  logic [BEAT_BITS-1:0] beat_data,
    output logic                 fwd_valid,
    output logic [BEAT_BITS-1:0] fwd_data,
    output logic [TAG_W-1:0]     fwd_tag,
    output logic                 line_done,
    output logic [ADDR_W-1:0]    line_addr,
    output logic [LINE_BITS-1:0] line_data
);
    typedef struct packed {
        fill_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [TAG_W-1:0]  tag;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             xfer;
    logic             cnt_load;
    logic [IDX_W-1:0] start_idx;
    logic [IDX_W-1:0] word_idx;
    logic             beat_first;
    logic             beat_last;

    assign start_idx = ctl_q.addr[WORD_LO +: IDX_W];
    assign xfer      = beat_valid && beat_ready;
    assign cnt_load  = (ctl_q.st == FS_CMD) && mem_cmd_ready;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            FS_IDLE: begin
                if (req_valid) begin
                    ctl_d.st   = FS_CMD;
                    ctl_d.addr = req_addr;
                    ctl_d.tag  = req_tag;
                end
            end
            FS_CMD: begin
                if (mem_cmd_ready)
                    ctl_d.st = FS_BEAT;
            end
            FS_BEAT: begin
                if (xfer && beat_last)
                    ctl_d.st = FS_DONE;
            end
            FS_DONE: ctl_d.st = FS_IDLE;
            default: ctl_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st   <= FS_IDLE;
            ctl_q.addr <= '0;
            ctl_q.tag  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    cwf_wrap_ctr #(.BEATS(BEATS)) i_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cnt_load),
        .step      (xfer),
        .start_idx (start_idx),
        .word_idx  (word_idx),
        .first     (beat_first),
        .last      (beat_last)
    );

    cwf_line_buf #(.BEATS(BEATS), .BEAT_BITS(BEAT_BITS)) i_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (xfer),
        .wr_idx  (word_idx),
        .wr_data (beat_data),
        .line    (line_data)
    );

    assign req_ready     = (ctl_q.st == FS_IDLE);
    assign mem_cmd_valid = (ctl_q.st == FS_CMD);
    assign mem_cmd_addr  = {ctl_q.addr[ADDR_W-1:WORD_LO], {WORD_LO{1'b0}}};
    assign beat_ready    = (ctl_q.st == FS_BEAT);
    assign fwd_valid     = xfer && beat_first;
    assign fwd_data      = beat_data;
    assign fwd_tag       = ctl_q.tag;
    assign line_done     = (ctl_q.st == FS_DONE);
    assign line_addr     = {ctl_q.addr[ADDR_W-1:LINE_LO], {LINE_LO{1'b0}}};

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid && !mem_cmd_ready) |=> (mem_cmd_valid && $stable(mem_cmd_addr))); // R2
    AST_FWD_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (beat_valid && beat_ready)); // R5
    AST_FWD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |=> !fwd_valid); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> (!line_done && req_ready)); // R6
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid || beat_ready || line_done) |-> !req_ready); // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ready && !beat_valid) |=> beat_ready); // R8
endmodule

// File: tb/test_cwf_line_fill.sv
module test_cwf_line_fill;
    localparam int AW = 32;
    localparam int TW = 8;
    localparam int BB = 64;
    localparam int NB = 8;
    localparam int LB = NB * BB;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_ready;
    logic [AW-1:0] req_addr;
    logic [TW-1:0] req_tag;
    logic          mem_cmd_valid, mem_cmd_ready;
    logic [AW-1:0] mem_cmd_addr;
    logic          beat_valid, beat_ready;
    logic [BB-1:0] beat_data;
    logic          fwd_valid;
    logic [BB-1:0] fwd_data;
    logic [TW-1:0] fwd_tag;
    logic          line_done;
    logic [AW-1:0] line_addr;
    logic [LB-1:0] line_data;

    always #4 clk = ~clk;

    cwf_line_fill i_cwf_line_fill (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_tag(req_tag),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready), .mem_cmd_addr(mem_cmd_addr),
        .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_data(beat_data),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_tag(fwd_tag),
        .line_done(line_done), .line_addr(line_addr), .line_data(line_data)
    );

    int checks = 0;
    int errors = 0;

    // reference model state
    int            m_phase;   // 0 idle, 1 command, 2 beats, 3 done
    int            m_count;
    int            m_start;
    logic [AW-1:0] m_addr;
    logic [TW-1:0] m_tag;
    logic [BB-1:0] m_line [NB];
    int            fill_no;

    function automatic logic [BB-1:0] word_val(int f, int w);
        return {32'(f) ^ 32'h5A00_0000, 32'(w) * 32'h1111_0001 ^ 32'hA5A5_0000};
    endfunction

    task automatic chk(input string req, input string nm, input logic [LB-1:0] act,
                       input logic [LB-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, nm, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [LB-1:0] flat;
        logic exp_fwd;
        exp_fwd = (m_phase == 2) && beat_valid && (m_count == 0);
        chk((m_phase == 0) ? "R1" : "R7", "req_ready", LB'(req_ready), LB'(m_phase == 0));
        chk("R2", "mem_cmd_valid", LB'(mem_cmd_valid), LB'(m_phase == 1));
        if (m_phase == 1)
            chk("R2", "mem_cmd_addr", LB'(mem_cmd_addr), LB'({m_addr[AW-1:3], 3'b000}));
        chk((m_phase == 2 && !beat_valid) ? "R8" : "R3", "beat_ready",
            LB'(beat_ready), LB'(m_phase == 2));
        chk("R5", "fwd_valid", LB'(fwd_valid), LB'(exp_fwd));
        if (exp_fwd) begin
            chk("R5", "fwd_data", LB'(fwd_data), LB'(beat_data));
            chk("R5", "fwd_tag", LB'(fwd_tag), LB'(m_tag));
        end
        chk("R6", "line_done", LB'(line_done), LB'(m_phase == 3));
        if (m_phase == 3) begin
            chk("R6", "line_addr", LB'(line_addr), LB'({m_addr[AW-1:6], 6'b0}));
            for (int w = 0; w < NB; w++) flat[w*BB +: BB] = m_line[w];
            chk("R4", "line_data model", line_data, flat);
            for (int w = 0; w < NB; w++) flat[w*BB +: BB] = word_val(fill_no, w);
            chk("R4", "line_data slots", line_data, flat);
        end
    endtask

    task automatic step_model();
        if (!rst_n) begin
            m_phase = 0; m_count = 0;
            return;
        end
        case (m_phase)
            0: if (req_valid) begin
                   m_phase = 1; m_addr = req_addr; m_tag = req_tag;
                   m_start = int'(req_addr[5:3]);
               end
            1: if (mem_cmd_ready) begin m_phase = 2; m_count = 0; end
            2: if (beat_valid) begin
                   m_line[(m_start + m_count) % NB] = beat_data;
                   m_count++;
                   if (m_count == NB) m_phase = 3;
               end
            default: begin m_phase = 0; fill_no++; end
        endcase
    endtask

    initial begin
        int cycles;
        int stall;
        logic [AW-1:0] plan_addr;
        m_phase = 0; m_count = 0; m_start = 0; m_addr = '0; m_tag = '0; fill_no = 0;
        for (int w = 0; w < NB; w++) m_line[w] = '0;
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_tag = '0;
        mem_cmd_ready = 1'b0; beat_valid = 1'b0; beat_data = '0;
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1; compare_all(); @(posedge clk); step_model();
        end
        @(negedge clk); rst_n = 1'b1;
        cycles = 0;
        while (fill_no < 3 * NB) begin
            stall = (fill_no < NB) ? 0 : ((fill_no < 2 * NB) ? 50 : 75);
            plan_addr = {20'(fill_no * 37 + 5), 3'(fill_no), 3'(fill_no % NB), 3'($urandom)};
            @(negedge clk);
            // R7: req_valid stays high with other addresses while busy
            req_valid     = 1'b1;
            req_addr      = (m_phase == 0) ? plan_addr : AW'($urandom);
            req_tag       = (m_phase == 0) ? TW'(fill_no + 8'h40) : TW'($urandom);
            mem_cmd_ready = int'($urandom % 100) >= stall;
            beat_valid    = int'($urandom % 100) >= stall;
            beat_data     = (m_phase == 2) ? word_val(fill_no, (m_start + m_count) % NB)
                                           : BB'($urandom);
            #1;
            compare_all();
            @(posedge clk);
            step_model();
            cycles++;
            if (cycles > 100000) begin
                errors++; checks++;
                $display("FAIL watchdog R3 actual=%0d expected=%0d fills", fill_no, 3 * NB);
                break;
            end
        end
        // idle with no request: stays idle (R7)
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); req_valid = 1'b0; beat_valid = 1'b1; mem_cmd_ready = 1'b1;
            #1; compare_all(); @(posedge clk); step_model();
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule